// File: doc/BRIEF.md
# Vertex Attribute Fetch Address Generator

This block turns a draw command into the list of memory byte addresses from which the vertex attribute data must be read. A draw is started by a pulse on one of two start pins. The first runs a plain draw, where the vertex numbers are consecutive. The second runs an indexed draw, where each vertex number is first read from an index array in memory. At that start pulse the block takes a private copy of the whole draw configuration:
- the attribute base address, held in units of 8 bytes;
- a per-loader enable mask, offset and bytes-per-vertex;
- the index array control word;
- the vertex count;
- the first vertex number.

For every vertex position, and for each enabled loader in ascending loader order, one tuple of (loader, vertex number, byte address) leaves on a valid/ready stream. When the stream is stalled (out_ready low while out_valid is high), the tuple is held unchanged until it is taken. Index reads go through a request/response port. A request is held stable until it is accepted. Its response comes back as a single-cycle valid with no back-pressure, and only one index read is ever outstanding. A single-cycle completion pulse closes every draw.

Top module: `attr_fetch_addr_gen`

## Requirements
- R1: On a start pulse while idle, all configuration inputs are captured. Configuration changes and start pulses that arrive while a draw is running have no effect on that draw's outputs.
- R2: Each output address equals base_div8×8 + loader offset + vertex number × loader bytes-per-vertex, taken modulo 2^32.
- R3: For each vertex position, one tuple is emitted per set bit of the loader mask, in ascending loader number. Positions are emitted in ascending order, from 0 up to count−1.
- R4: In a plain draw, the vertex number at position p is first + p, modulo 2^32.
- R5: In an indexed draw, the index read address for position p is base_div8×8 + index offset + p×size. The index offset is bits [30:0] of the index control word. Bit 31 of that word selects the size: 0 means 1-byte indices, which are taken from mem_rsp_data[7:0]. 1 means 2-byte little-endian indices, taken from mem_rsp_data[15:0], where bits [7:0] hold the byte at the request address and bits [15:8] hold the byte above it.
- R6: At most one index read is outstanding. After a request is accepted, no new request is raised until its response has arrived and all tuples of that vertex have been accepted. The request port and the output stream are never valid in the same cycle.
- R7: A stalled output tuple, and an unaccepted index request, keep valid high and hold their data stable.
- R8: done is high for exactly one cycle. It comes in the cycle after the last tuple is accepted. If the count is zero or the mask is empty, done comes in the cycle after the start pulse, with no tuples and no index reads.
- R9: If both start pins pulse in the same cycle, the draw runs as an indexed draw.
- R10: During and right after reset, out_valid, mem_req_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_plain | input | 1 | Start a non-indexed draw |
| start_indexed | input | 1 | Start an indexed draw |
| cfg_base_div8 | input | ADDR_W-3 | Attribute base address divided by 8 |
| cfg_ldr_mask | input | NUM_LDR | Loader enable, one bit per loader |
| cfg_ldr_offset | input | NUM_LDR*ADDR_W | Per-loader byte offset from the base, loader i at bits [i*ADDR_W +: ADDR_W] |
| cfg_ldr_bytes | input | NUM_LDR*BCNT_W | Per-loader bytes per vertex, loader i at bits [i*BCNT_W +: BCNT_W] |
| cfg_index_ctl | input | ADDR_W | MSB selects 2-byte indices; the remaining bits are the index array offset |
| cfg_vtx_count | input | ADDR_W | Number of vertices |
| cfg_vtx_first | input | ADDR_W | First vertex number for plain draws |
| mem_req_valid | output | 1 | Index read request valid |
| mem_req_ready | input | 1 | Index read request accepted |
| mem_req_addr | output | ADDR_W | Byte address of the index |
| mem_rsp_valid | input | 1 | Index read data valid, one cycle |
| mem_rsp_data | input | 16 | Bytes at addr (low) and addr+1 (high) |
| out_valid | output | 1 | Address tuple valid |
| out_ready | input | 1 | Address tuple accepted |
| out_loader | output | LDR_W | Loader number of the tuple |
| out_vertex | output | ADDR_W | Vertex number of the tuple |
| out_addr | output | ADDR_W | Byte address of the tuple |
| done | output | 1 | One-cycle completion pulse |

## Verification
The timing of each result is fixed relative to the clock edge that causes it:
- A start edge puts the first index request, or the first tuple, on the ports one register stage later.
- An empty draw raises done after that same single stage.
- An index response is turned into the first tuple of its vertex one cycle after the response is taken.
- done follows the edge that accepts the last tuple by exactly one cycle.

The bench drives and samples on the falling edge. When it sees valid together with the ready it has just chosen, it treats that as a transfer at the next rising edge and checks it then. done is required on the very next falling edge after the last transfer, and for an empty draw on the falling edge right after the start.

// File: rtl/attr_fetch_pkg.sv
package attr_fetch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_IREQ  = 3'd1,
    ST_IWAIT = 3'd2,
    ST_EMIT  = 3'd3,
    ST_DONE  = 3'd4
  } fetch_state_t;

  localparam int IDX_DATA_W = 16;
endpackage

// File: rtl/attr_cfg_latch.sv
module attr_cfg_latch #(
  parameter int NUM_LDR = 12,
  parameter int ADDR_W  = 32,
  parameter int BCNT_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [ADDR_W-4:0]         in_base_div8,
  input  logic [NUM_LDR-1:0]        in_mask,
  input  logic [NUM_LDR*ADDR_W-1:0] in_offset,
  input  logic [NUM_LDR*BCNT_W-1:0] in_bytes,
  input  logic [ADDR_W-1:0]         in_index_ctl,
  input  logic [ADDR_W-1:0]         in_count,
  output logic [ADDR_W-4:0]         q_base_div8,
  output logic [NUM_LDR-1:0]        q_mask,
  output logic [NUM_LDR*ADDR_W-1:0] q_offset,
  output logic [NUM_LDR*BCNT_W-1:0] q_bytes,
  output logic [ADDR_W-2:0]         q_idx_off,
  output logic                      q_idx_wide,
  output logic [ADDR_W-1:0]         q_count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_base_div8 <= '0;
      q_mask      <= '0;
      q_offset    <= '0;
      q_bytes     <= '0;
      q_idx_off   <= '0;
      q_idx_wide  <= 1'b0;
      q_count     <= '0;
    end else if (load) begin
      q_base_div8 <= in_base_div8;
      q_mask      <= in_mask;
      q_offset    <= in_offset;
      q_bytes     <= in_bytes;
      q_idx_off   <= in_index_ctl[ADDR_W-2:0];
      q_idx_wide  <= in_index_ctl[ADDR_W-1];
      q_count     <= in_count;
    end
  end
endmodule

// File: rtl/attr_ldr_pick.sv
module attr_ldr_pick #(
  parameter int NUM_LDR = 12,
  parameter int LDR_W   = 4
) (
  input  logic [NUM_LDR-1:0] mask,
  input  logic [LDR_W-1:0]   cur,
  input  logic               from_start,
  output logic [LDR_W-1:0]   pick,
  output logic               found
);
  // Lowest enabled loader above cur (or lowest overall when from_start).
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NUM_LDR - 1; i >= 0; i--) begin
      if (mask[i] && (from_start || (LDR_W'(i) > cur))) begin
        pick  = LDR_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/attr_addr_calc.sv
module attr_addr_calc #(
  parameter int ADDR_W = 32,
  parameter int BCNT_W = 8
) (
  input  logic [ADDR_W-4:0] base_div8,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] vertex,
  input  logic [BCNT_W-1:0] bytes,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] stride_term;

  always_comb begin
    stride_term = vertex * ADDR_W'(bytes);
    addr        = {base_div8, 3'b000} + offset + stride_term;
  end
endmodule

// File: rtl/attr_fetch_addr_gen.sv
module attr_fetch_addr_gen
  import attr_fetch_pkg::*;
#(
  parameter int NUM_LDR = 12,
  parameter int ADDR_W  = 32,
  parameter int BCNT_W  = 8,
  localparam int LDR_W  = $clog2(NUM_LDR)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_plain,
  input  logic                      start_indexed,
  input  logic [ADDR_W-4:0]         cfg_base_div8,
  input  logic [NUM_LDR-1:0]        cfg_ldr_mask,
  input  logic [NUM_LDR*ADDR_W-1:0] cfg_ldr_offset,
  input  logic [NUM_LDR*BCNT_W-1:0] cfg_ldr_bytes,
  input  logic [ADDR_W-1:0]         cfg_index_ctl,
  input  logic [ADDR_W-1:0]         cfg_vtx_count,
  input  logic [ADDR_W-1:0]         cfg_vtx_first,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [ADDR_W-1:0]         mem_req_addr,
  input  logic                      mem_rsp_valid,
  input  logic [IDX_DATA_W-1:0]     mem_rsp_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LDR_W-1:0]          out_loader,
  output logic [ADDR_W-1:0]         out_vertex,
  output logic [ADDR_W-1:0]         out_addr,
  output logic                      done
);
  fetch_state_t state;
  logic [ADDR_W-1:0] pos;
  logic [ADDR_W-1:0] vtx;
  logic [LDR_W-1:0]  ldr;
  logic              idx_mode;

  logic [ADDR_W-4:0]         lat_base;
  logic [NUM_LDR-1:0]        lat_mask;
  logic [NUM_LDR*ADDR_W-1:0] lat_off;
  logic [NUM_LDR*BCNT_W-1:0] lat_bytes;
  logic [ADDR_W-2:0]         lat_idx_off;
  logic                      lat_wide;
  logic [ADDR_W-1:0]         lat_count;

  logic load;
  logic empty_in;
  logic last_pos;
  assign load     = (state == ST_IDLE) && (start_plain || start_indexed);
  assign empty_in = (cfg_vtx_count == '0) || (cfg_ldr_mask == '0);
  assign last_pos = (pos == lat_count - ADDR_W'(1));

  attr_cfg_latch #(.NUM_LDR(NUM_LDR), .ADDR_W(ADDR_W), .BCNT_W(BCNT_W)) i_latch (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .in_base_div8 (cfg_base_div8),
    .in_mask      (cfg_ldr_mask),
    .in_offset    (cfg_ldr_offset),
    .in_bytes     (cfg_ldr_bytes),
    .in_index_ctl (cfg_index_ctl),
    .in_count     (cfg_vtx_count),
    .q_base_div8  (lat_base),
    .q_mask       (lat_mask),
    .q_offset     (lat_off),
    .q_bytes      (lat_bytes),
    .q_idx_off    (lat_idx_off),
    .q_idx_wide   (lat_wide),
    .q_count      (lat_count)
  );

  // Loader selection: first enabled loader and the one after the current.
  logic [NUM_LDR-1:0] first_mask;
  logic [LDR_W-1:0]   first_ldr;
  logic               first_found;
  logic [LDR_W-1:0]   next_ldr;
  logic               next_found;
  assign first_mask = (state == ST_IDLE) ? cfg_ldr_mask : lat_mask;

  attr_ldr_pick #(.NUM_LDR(NUM_LDR), .LDR_W(LDR_W)) i_pick_first (
    .mask       (first_mask),
    .cur        ('0),
    .from_start (1'b1),
    .pick       (first_ldr),
    .found      (first_found)
  );

  attr_ldr_pick #(.NUM_LDR(NUM_LDR), .LDR_W(LDR_W)) i_pick_next (
    .mask       (lat_mask),
    .cur        (ldr),
    .from_start (1'b0),
    .pick       (next_ldr),
    .found      (next_found)
  );

  // Per-loader parameter selection.
  logic [ADDR_W-1:0] sel_off;
  logic [BCNT_W-1:0] sel_bytes;
  always_comb begin
    sel_off   = '0;
    sel_bytes = '0;
    for (int i = 0; i < NUM_LDR; i++) begin
      if (LDR_W'(i) == ldr) begin
        sel_off   = lat_off[i*ADDR_W +: ADDR_W];
        sel_bytes = lat_bytes[i*BCNT_W +: BCNT_W];
      end
    end
  end

  attr_addr_calc #(.ADDR_W(ADDR_W), .BCNT_W(BCNT_W)) i_calc (
    .base_div8 (lat_base),
    .offset    (sel_off),
    .vertex    (vtx),
    .bytes     (sel_bytes),
    .addr      (out_addr)
  );

  // Index read address.
  logic [ADDR_W-1:0] idx_step;
  assign idx_step     = lat_wide ? {pos[ADDR_W-2:0], 1'b0} : pos;
  assign mem_req_addr = {lat_base, 3'b000} + {1'b0, lat_idx_off} + idx_step;

  logic [ADDR_W-1:0] rsp_index;
  assign rsp_index = lat_wide ? ADDR_W'(mem_rsp_data) : ADDR_W'(mem_rsp_data[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pos      <= '0;
      vtx      <= '0;
      ldr      <= '0;
      idx_mode <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (load) begin
            pos      <= '0;
            vtx      <= cfg_vtx_first;
            ldr      <= first_ldr;
            idx_mode <= start_indexed;
            if (empty_in || !first_found) state <= ST_DONE;
            else if (start_indexed)       state <= ST_IREQ;
            else                          state <= ST_EMIT;
          end
        end
        ST_IREQ: begin
          if (mem_req_ready) state <= ST_IWAIT;
        end
        ST_IWAIT: begin
          if (mem_rsp_valid) begin
            vtx   <= rsp_index;
            ldr   <= first_ldr;
            state <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            if (next_found) begin
              ldr <= next_ldr;
            end else if (last_pos) begin
              state <= ST_DONE;
            end else begin
              pos <= pos + ADDR_W'(1);
              ldr <= first_ldr;
              if (idx_mode) state <= ST_IREQ;
              else          vtx   <= vtx + ADDR_W'(1);
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == ST_IREQ);
  assign out_valid     = (state == ST_EMIT);
  assign out_loader    = ldr;
  assign out_vertex    = vtx;
  assign done          = (state == ST_DONE);
endmodule

// File: rtl/attr_fetch_checker.sv
module attr_fetch_checker #(
  parameter int NUM_LDR = 12,
  parameter int ADDR_W  = 32,
  parameter int LDR_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LDR_W-1:0]  out_loader,
  input logic [ADDR_W-1:0] out_vertex,
  input logic [ADDR_W-1:0] out_addr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              done
);
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_vertex)
                                && $stable(out_loader));

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  p_port_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && mem_req_valid));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid && !mem_req_valid);

  p_loader_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_loader < LDR_W'(NUM_LDR)));
endmodule

bind attr_fetch_addr_gen attr_fetch_checker #(
  .NUM_LDR (NUM_LDR),
  .ADDR_W  (ADDR_W),
  .LDR_W   (LDR_W)
) i_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_loader    (out_loader),
  .out_vertex    (out_vertex),
  .out_addr      (out_addr),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done          (done)
);

// File: tb/test_attr_fetch_addr_gen.sv
module test_attr_fetch_addr_gen;
  localparam int NL = 12;
  localparam int AW = 32;
  localparam int BW = 8;
  localparam int LW = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              start_plain = 0, start_indexed = 0;
  logic [AW-4:0]     cfg_base_div8 = '0;
  logic [NL-1:0]     cfg_ldr_mask = '0;
  logic [NL*AW-1:0]  cfg_ldr_offset = '0;
  logic [NL*BW-1:0]  cfg_ldr_bytes = '0;
  logic [AW-1:0]     cfg_index_ctl = '0, cfg_vtx_count = '0, cfg_vtx_first = '0;
  logic              mem_req_valid, mem_req_ready = 0;
  logic [AW-1:0]     mem_req_addr;
  logic              mem_rsp_valid = 0;
  logic [15:0]       mem_rsp_data = '0;
  logic              out_valid, out_ready = 0, done;
  logic [LW-1:0]     out_loader;
  logic [AW-1:0]     out_vertex, out_addr;

  attr_fetch_addr_gen #(.NUM_LDR(NL), .ADDR_W(AW), .BCNT_W(BW)) i_attr_fetch_addr_gen (
    .clk(clk), .rst_n(rst_n), .start_plain(start_plain), .start_indexed(start_indexed),
    .cfg_base_div8(cfg_base_div8), .cfg_ldr_mask(cfg_ldr_mask), .cfg_ldr_offset(cfg_ldr_offset),
    .cfg_ldr_bytes(cfg_ldr_bytes), .cfg_index_ctl(cfg_index_ctl), .cfg_vtx_count(cfg_vtx_count),
    .cfg_vtx_first(cfg_vtx_first), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_loader(out_loader),
    .out_vertex(out_vertex), .out_addr(out_addr), .done(done));

  int n_checks = 0;
  int n_fail = 0;

  // Expected configuration, saved at the start pulse.
  logic [AW-4:0] e_base;
  logic [NL-1:0] e_mask;
  logic [AW-1:0] e_off [NL];
  logic [BW-1:0] e_bytes [NL];
  logic [AW-2:0] e_idx_off;
  logic          e_wide, e_indexed;
  logic [AW-1:0] e_count, e_first;

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic logic [AW-1:0] exp_iaddr(input logic [AW-1:0] p);
    logic [AW-1:0] step;
    step = e_wide ? (p << 1) : p;
    return {e_base, 3'b000} + {1'b0, e_idx_off} + step;
  endfunction

  function automatic logic [AW-1:0] exp_vertex(input logic [AW-1:0] p);
    logic [AW-1:0] a;
    if (!e_indexed) return e_first + p;
    a = exp_iaddr(p);
    if (e_wide) return {16'h0, mem_byte(a + 1), mem_byte(a)};
    return {24'h0, mem_byte(a)};
  endfunction

  function automatic logic [AW-1:0] exp_addr(input int l, input logic [AW-1:0] v);
    logic [AW-1:0] r;
    r = {e_base, 3'b000} + e_off[l] + v * AW'(e_bytes[l]);
    return r;
  endfunction

  function automatic int first_bit(input logic [NL-1:0] m, input int after);
    for (int i = 0; i < NL; i++) if (m[i] && i > after) return i;
    return -1;
  endfunction

  task automatic set_random_cfg();
    cfg_base_div8 = AW'($urandom);
    cfg_ldr_mask  = NL'($urandom);
    if ($urandom % 6 == 0) cfg_ldr_mask = '0;
    for (int l = 0; l < NL; l++) begin
      cfg_ldr_offset[l*AW +: AW] = $urandom;
      cfg_ldr_bytes[l*BW +: BW]  = BW'($urandom);
    end
    cfg_index_ctl = $urandom;
    cfg_vtx_count = $urandom % 6;
    cfg_vtx_first = $urandom;
  endtask

  task automatic run_draw(input bit plain, input bit indexed, input bit meddle);
    int total, k, ep, el, cyc;
    bit last_sent, pend, rdy, qr;
    int dly;
    logic [15:0] pdata;
    e_base = cfg_base_div8; e_mask = cfg_ldr_mask; e_idx_off = cfg_index_ctl[AW-2:0];
    e_wide = cfg_index_ctl[AW-1]; e_count = cfg_vtx_count; e_first = cfg_vtx_first;
    e_indexed = indexed;
    for (int l = 0; l < NL; l++) begin
      e_off[l] = cfg_ldr_offset[l*AW +: AW];
      e_bytes[l] = cfg_ldr_bytes[l*BW +: BW];
    end
    start_plain = plain; start_indexed = indexed;
    @(negedge clk);
    start_plain = 0; start_indexed = 0;
    if (meddle) set_random_cfg();
    total = (e_mask == '0) ? 0 : int'(e_count) * $countones(e_mask);
    if (total == 0) begin
      chk(done == 1'b1, "R8 empty draw done", AW'(done), 1);
      chk(!out_valid && !mem_req_valid, "R8 empty draw quiet", AW'(out_valid), 0);
      @(negedge clk);
      chk(done == 1'b0, "R8 done single cycle", AW'(done), 0);
      return;
    end
    if (indexed) chk(mem_req_valid == 1'b1, "R9 R5 indexed request first", AW'(mem_req_valid), 1);
    else chk(out_valid == 1'b1, "R4 plain first tuple", AW'(out_valid), 1);
    k = 0; ep = 0; el = first_bit(e_mask, -1); last_sent = 0; pend = 0; dly = 0; pdata = '0;
    cyc = 0;
    forever begin
      cyc++;
      if (cyc > 3000) begin
        chk(1'b0, "watchdog draw hung", AW'(k), AW'(total));
        break;
      end
      start_plain = 0; start_indexed = 0;
      if (meddle && (cyc == 3 || cyc == 7)) begin
        start_plain = 1; start_indexed = 1;   // R1: ignored while busy
      end
      if (done) begin
        chk(last_sent && k == total, "R8 R3 done after all tuples", AW'(k), AW'(total));
        break;
      end
      if (last_sent) begin
        chk(1'b0, "R8 done late", AW'(done), 1);
        break;
      end
      mem_rsp_valid = 0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = pdata; pend = 0;
        end else dly--;
      end
      rdy = ($urandom % 4) != 0;
      out_ready = rdy;
      if (out_valid && rdy) begin
        logic [AW-1:0] v;
        v = exp_vertex(AW'(ep));
        chk(out_loader == LW'(el), "R3 R1 loader order", AW'(out_loader), AW'(el));
        chk(out_vertex == v, e_indexed ? "R5 indexed vertex" : "R4 plain vertex", out_vertex, v);
        chk(out_addr == exp_addr(el, v), "R2 byte address", out_addr, exp_addr(el, v));
        k++;
        el = first_bit(e_mask, el);
        if (el < 0) begin ep++; el = first_bit(e_mask, -1); end
        if (k == total) last_sent = 1;
      end
      qr = ($urandom % 3) != 0;
      mem_req_ready = qr;
      if (mem_req_valid) begin
        chk(e_indexed, "R4 no index reads in plain draw", AW'(mem_req_valid), 0);
        chk(!pend && !mem_rsp_valid, "R6 single outstanding read", AW'(pend), 0);
        if (qr) begin
          chk(mem_req_addr == exp_iaddr(AW'(ep)), "R5 index read address", mem_req_addr,
              exp_iaddr(AW'(ep)));
          pend = 1; dly = $urandom % 3;
          pdata = {mem_byte(mem_req_addr + 1), mem_byte(mem_req_addr)};
        end
      end
      @(negedge clk);
    end
    out_ready = 0; mem_req_ready = 0; mem_rsp_valid = 0; start_plain = 0; start_indexed = 0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog global timeout", 0, 0);
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!out_valid && !mem_req_valid && !done, "R10 in reset", AW'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !mem_req_valid && !done, "R10 after reset", AW'(done), 0);

    // R4 plain draw, three loaders.
    set_random_cfg();
    cfg_ldr_mask = 12'b1000_0010_0001; cfg_vtx_count = 3; cfg_vtx_first = 32'd100;
    run_draw(1, 0, 0);
    // R5 narrow indices.
    set_random_cfg();
    cfg_ldr_mask = 12'h0F0; cfg_vtx_count = 4; cfg_index_ctl = 32'h0000_1235;
    run_draw(0, 1, 0);
    // R5 wide little-endian indices.
    set_random_cfg();
    cfg_ldr_mask = 12'h801; cfg_vtx_count = 4; cfg_index_ctl = 32'h8000_2001;
    run_draw(0, 1, 0);
    // R2 wrap-around modulo 2^32.
    set_random_cfg();
    cfg_base_div8 = '1; cfg_ldr_mask = 12'h003; cfg_vtx_count = 2; cfg_vtx_first = 32'hFFFF_FFF0;
    cfg_ldr_offset[0 +: AW] = 32'hFFFF_FF00; cfg_ldr_bytes[0 +: BW] = 8'hFF;
    run_draw(1, 0, 0);
    // R8 zero vertices and empty mask.
    set_random_cfg(); cfg_vtx_count = 0; cfg_ldr_mask = 12'hFFF;
    run_draw(0, 1, 0);
    set_random_cfg(); cfg_vtx_count = 5; cfg_ldr_mask = '0;
    run_draw(1, 0, 0);
    // R9 both starts, R1 inputs changed and restarted while busy.
    set_random_cfg(); cfg_ldr_mask = 12'h249; cfg_vtx_count = 3;
    run_draw(1, 1, 1);
    set_random_cfg(); cfg_ldr_mask = 12'hFFF; cfg_vtx_count = 2;
    run_draw(1, 0, 1);
    // Constrained random mix.
    for (int t = 0; t < 40; t++) begin
      bit ix;
      set_random_cfg();
      ix = $urandom % 2;
      run_draw(!ix, ix, ($urandom % 3) == 0);
    end
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule